// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Translator

This block turns a 16-bit logical address into a 20-bit physical address, which gives a 1 MB physical space. The logical space is cut into four regions. The low root region is never relocated. Above it sit a data region and a stack region, each moved through physical memory by its own 8-bit base register. The top 8K is an extended window, and a dedicated page register positions that window anywhere in physical memory. The boundaries between root, data and stack are programmable in 4K steps through one 8-bit boundary register that holds two 4-bit fields.

Software programs the four 8-bit registers through a simple write port: an address, a data byte and a write enable. A write is captured on the next rising clock edge. The translate port is purely combinational. A new logical address yields its physical address and a 2-bit region tag in the same cycle, using the register values currently held.

Top module: `seg_mmu`

## Requirements
- R1: After synchronous reset, the boundary register holds 0xD8 (stack starts at 52K, data starts at 32K) and the data base, stack base and page registers all hold zero, so every logical address translates to its own zero-extended value.
- R2: When the logical address is below the data start boundary, and below both the stack start and 0xE000, the region tag is 0 (root) and the physical address is the logical address zero-extended to 20 bits.
- R3: When logical bits [15:12] are at or above the data start field (boundary bits [3:0]) but below the stack start field (boundary bits [7:4]) and the address is below 0xE000, the tag is 1 (data) and the physical address is the logical address plus the data base shifted left by 12.
- R4: When logical bits [15:12] are at or above the stack start field and the address is below 0xE000, the tag is 2 (stack) and the physical address is the logical address plus the stack base shifted left by 12.
- R5: Any logical address at or above 0xE000 gets tag 3 (extended window), whatever the boundary fields hold. Its physical address is the logical address plus the page register shifted left by 12.
- R6: When a nibble satisfies both the stack and data comparisons, the stack region wins. If the data start field is greater than the stack start field, no address is tagged data.
- R7: Register address 0 writes the boundary register, 1 the data base, 2 the stack base and 3 the page register. A write changes translation only after the next rising clock edge, and no register changes while the write enable is low.
- R8: A relocated sum that exceeds 20 bits is truncated to its low 20 bits, so the address wraps around to the bottom of physical memory.
- R9: Translation is combinational. A change on the logical address input shows up on the physical address and region tag outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register file |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register select: 0 boundary, 1 data base, 2 stack base, 3 page |
| cfg_wdata_i | input | 8 | Register write data |
| la_i | input | 16 | Logical address to translate |
| pa_o | output | 20 | Translated physical address |
| region_o | output | 2 | Region tag: 0 root, 1 data, 2 stack, 3 extended window |

## Verification
The assertions assume that the logical address and the write port are stable around the rising clock edge. They also assume that reset is held for at least one edge before any check matters. The bench keeps within this by changing every input only on the falling edge and sampling between edges. The assertions do not assume that the boundary fields are ordered. The stimulus therefore includes layouts with an empty root region, an inverted data and stack pair, and an all-ones boundary, as well as base values that force a 20-bit wrap. Every nibble of the logical space is swept under each layout.

// File: rtl/seg_mmu_pkg.sv
package seg_mmu_pkg;

  localparam int LA_W      = 16;
  localparam int PA_W      = 20;
  localparam int REG_W     = 8;
  localparam int NIB_W     = 4;
  localparam int PAGE_SH   = 12;
  localparam int EXT_BITS  = 3;
  localparam int NUM_REGS  = 4;
  localparam int CFG_AW    = $clog2(NUM_REGS);

  localparam int REG_BOUND = 0;
  localparam int REG_DBASE = 1;
  localparam int REG_SBASE = 2;
  localparam int REG_PAGE  = 3;

  localparam logic [REG_W-1:0] BOUND_RST = 8'hD8;

  typedef enum logic [1:0] {
    RGN_ROOT  = 2'd0,
    RGN_DATA  = 2'd1,
    RGN_STACK = 2'd2,
    RGN_EXT   = 2'd3
  } region_e;

  function automatic logic [REG_W-1:0] reg_reset(input int idx);
    return (idx == REG_BOUND) ? BOUND_RST : '0;
  endfunction

endpackage

// File: rtl/seg_mmu_regs.sv
module seg_mmu_regs
  import seg_mmu_pkg::*;
#(
  parameter int N_REGS = NUM_REGS,
  parameter int AW     = CFG_AW,
  parameter int DW     = REG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [N_REGS-1:0][DW-1:0] regs_o
);

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= reg_reset(g);
      end else if (we_i && (addr_i == AW'(g))) begin
        q <= wdata_i;
      end
    end
    assign regs_o[g] = q;
  end

endmodule

// File: rtl/seg_mmu_decode.sv
module seg_mmu_decode
  import seg_mmu_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int XB = EXT_BITS
) (
  input  logic [NW-1:0]   nib_i,
  input  logic [2*NW-1:0] bound_i,
  output region_e         region_o
);

  localparam int XLO = NW - XB;

  logic [NW-1:0] data_start;
  logic [NW-1:0] stack_start;
  logic          in_ext;
  logic          in_stack;
  logic          in_data;

  assign data_start  = bound_i[NW-1:0];
  assign stack_start = bound_i[2*NW-1:NW];
  assign in_ext      = &nib_i[NW-1:XLO];
  assign in_stack    = (nib_i >= stack_start);
  assign in_data     = (nib_i >= data_start);

  // Priority: extended window, then stack, then data, then root.
  always_comb begin
    if (in_ext)        region_o = RGN_EXT;
    else if (in_stack) region_o = RGN_STACK;
    else if (in_data)  region_o = RGN_DATA;
    else               region_o = RGN_ROOT;
  end

endmodule

// File: rtl/seg_mmu_reloc.sv
module seg_mmu_reloc
  import seg_mmu_pkg::*;
#(
  parameter int LW = LA_W,
  parameter int PW = PA_W,
  parameter int BW = REG_W,
  parameter int SH = PAGE_SH
) (
  input  logic [LW-1:0]      la_i,
  input  logic [2:0][BW-1:0] base_i,
  input  region_e            region_i,
  output logic [PW-1:0]      pa_o
);

  // base_i index: 0 data, 1 stack, 2 page.
  logic [2:0][PW-1:0] sum;

  for (genvar k = 0; k < 3; k++) begin : g_add
    logic [PW-1:0] offs;
    assign offs   = PW'(base_i[k]) << SH;
    assign sum[k] = PW'(la_i) + offs;
  end

  always_comb begin
    unique case (region_i)
      RGN_DATA:  pa_o = sum[0];
      RGN_STACK: pa_o = sum[1];
      RGN_EXT:   pa_o = sum[2];
      default:   pa_o = PW'(la_i);
    endcase
  end

endmodule

// File: rtl/seg_mmu.sv
module seg_mmu
  import seg_mmu_pkg::*;
#(
  parameter int LW = LA_W,
  parameter int PW = PA_W,
  parameter int BW = REG_W,
  parameter int AW = CFG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [BW-1:0] cfg_wdata_i,
  input  logic [LW-1:0] la_i,
  output logic [PW-1:0] pa_o,
  output logic [1:0]    region_o
);

  localparam int NW = BW / 2;

  logic [NUM_REGS-1:0][BW-1:0] regs;
  logic [BW-1:0]               bound_q;
  logic [BW-1:0]               data_base_q;
  logic [BW-1:0]               stack_base_q;
  logic [BW-1:0]               page_q;
  region_e                     region;

  seg_mmu_regs #(.N_REGS(NUM_REGS), .AW(AW), .DW(BW)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .regs_o  (regs)
  );

  assign bound_q      = regs[REG_BOUND];
  assign data_base_q  = regs[REG_DBASE];
  assign stack_base_q = regs[REG_SBASE];
  assign page_q       = regs[REG_PAGE];

  seg_mmu_decode #(.NW(NW), .XB(EXT_BITS)) dec_i (
    .nib_i    (la_i[LW-1 -: NW]),
    .bound_i  (bound_q),
    .region_o (region)
  );

  seg_mmu_reloc #(.LW(LW), .PW(PW), .BW(BW), .SH(PAGE_SH)) rel_i (
    .la_i     (la_i),
    .base_i   ({page_q, stack_base_q, data_base_q}),
    .region_i (region),
    .pa_o     (pa_o)
  );

  assign region_o = region;

endmodule

// File: rtl/seg_mmu_chk.sv
module seg_mmu_chk
  import seg_mmu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              we_i,
  input logic [LA_W-1:0]   la_i,
  input logic [PA_W-1:0]   pa_o,
  input logic [1:0]        region_o,
  input logic [REG_W-1:0]  bound,
  input logic [REG_W-1:0]  data_base,
  input logic [REG_W-1:0]  stack_base,
  input logic [REG_W-1:0]  page
);

  logic [PA_W-1:0] la_ext;
  assign la_ext = PA_W'(la_i);

  // R1
  a_r1_reset_bound: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bound == BOUND_RST && data_base == '0 && stack_base == '0 && page == '0));

  // R2
  a_r2_root_identity: assert property (@(posedge clk) disable iff (rst)
    (region_o == 2'(RGN_ROOT)) |-> (pa_o == la_ext));

  // R3
  a_r3_data_window: assert property (@(posedge clk) disable iff (rst)
    (region_o == 2'(RGN_DATA)) |->
      (la_i[15:12] >= bound[3:0] && la_i[15:12] < bound[7:4] &&
       pa_o == la_ext + (PA_W'(data_base) << PAGE_SH)));

  // R4
  a_r4_stack_offset: assert property (@(posedge clk) disable iff (rst)
    (region_o == 2'(RGN_STACK)) |-> (pa_o == la_ext + (PA_W'(stack_base) << PAGE_SH)));

  // R5
  a_r5_ext_window: assert property (@(posedge clk) disable iff (rst)
    (la_i[15:13] == 3'b111) |-> (region_o == 2'(RGN_EXT)));

  // R6
  a_r6_stack_wins: assert property (@(posedge clk) disable iff (rst)
    (la_i[15:13] != 3'b111 && la_i[15:12] >= bound[7:4]) |-> (region_o == 2'(RGN_STACK)));

  // R7
  a_r7_hold_regs: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> ($stable(bound) && $stable(data_base) && $stable(stack_base) && $stable(page)));

endmodule

bind seg_mmu seg_mmu_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .we_i       (cfg_we_i),
  .la_i       (la_i),
  .pa_o       (pa_o),
  .region_o   (region_o),
  .bound      (bound_q),
  .data_base  (data_base_q),
  .stack_base (stack_base_q),
  .page       (page_q)
);

// File: tb/seg_mmu_tb.sv
module seg_mmu_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        we;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [15:0] la;
  logic [19:0] pa;
  logic [1:0]  rg;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_bound, m_db, m_sb, m_pg;

  always #4 clk = ~clk;

  seg_mmu dut_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .la_i        (la),
    .pa_o        (pa),
    .region_o    (rg)
  );

  function automatic logic [1:0] exp_rg(input logic [15:0] a);
    if (a >= 16'hE000)              return 2'd3;
    if (a[15:12] >= m_bound[7:4])   return 2'd2;
    if (a[15:12] >= m_bound[3:0])   return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [19:0] exp_pa(input logic [15:0] a);
    int unsigned base;
    case (exp_rg(a))
      2'd1:    base = m_db;
      2'd2:    base = m_sb;
      2'd3:    base = m_pg;
      default: base = 0;
    endcase
    return 20'((int'(a) + base * 4096) % 1048576);
  endfunction

  task automatic check(input string tag, input logic [19:0] epa, input logic [1:0] erg);
    checks++;
    if (pa !== epa || rg !== erg) begin
      errors++;
      $display("FAIL %s la=%h pa=%h rg=%0d expected pa=%h rg=%0d", tag, la, pa, rg, epa, erg);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      2'd0: m_bound = d;
      2'd1: m_db = d;
      2'd2: m_sb = d;
      default: m_pg = d;
    endcase
  endtask

  task automatic probe(input string tag, input logic [15:0] a);
    @(negedge clk);
    la = a;
    #2;
    check(tag, exp_pa(a), exp_rg(a));
  endtask

  // R9: each probe checks within the same half cycle the address changed.
  task automatic sweep(input string extra);
    for (int n = 0; n < 16; n++) begin
      for (int o = 0; o < 3; o++) begin
        logic [15:0] a;
        string tag;
        a = {4'(n), (o == 0) ? 12'h000 : (o == 1) ? 12'hFFF : 12'h7A5};
        case (exp_rg(a))
          2'd0: tag = "R2";
          2'd1: tag = "R3";
          2'd2: tag = "R4";
          default: tag = "R5";
        endcase
        probe({tag, "/R9", extra}, a);
      end
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; la = '0;
    m_bound = 8'hD8; m_db = '0; m_sb = '0; m_pg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset layout translates identically
    probe("R1", 16'h1234);
    probe("R1", 16'h9000);
    probe("R1", 16'hD000);
    probe("R1", 16'hE000);
    sweep("/R1");

    // R7: write takes effect only after the clock edge
    @(negedge clk);
    la = 16'h9000; we = 1'b1; addr = 2'd1; wdata = 8'h55;
    #2;
    check("R7", 20'h09000, 2'd1);
    @(posedge clk);
    #2;
    check("R7", 20'h5E000, 2'd1);
    @(negedge clk);
    we = 1'b0; m_db = 8'h55;

    // R7: write enable low leaves the page register untouched
    @(negedge clk);
    addr = 2'd3; wdata = 8'hAA;
    repeat (2) @(negedge clk);
    probe("R7", 16'hE123);
    probe("R7", 16'hA000);

    // R3/R4/R5: new layout and bases
    wr(2'd0, 8'hA4);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h30);
    sweep("");

    // R6: data start above stack start leaves no data region
    wr(2'd0, 8'h37);
    sweep("/R6");

    // R5/R6: all-ones boundary
    wr(2'd0, 8'hFF);
    sweep("/R6");

    // R2 boundary: empty root, everything below E000 is stack
    wr(2'd0, 8'h00);
    sweep("/R6");

    // R8: wrap past 1 MB
    wr(2'd0, 8'hC6);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hF8);
    wr(2'd3, 8'hFE);
    sweep("/R8");
    probe("R8", 16'hFFFF);
    probe("R8", 16'hBFFF);

    // R7: register mapping, each address steers only its own register
    wr(2'd3, 8'h01);
    probe("R7", 16'hE000);
    probe("R7", 16'hC000);
    probe("R7", 16'h6000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule